// File: doc/BRIEF.md
# Chained-Rule Frame Filter

This block decides whether a received frame is kept or dropped. A parser outside the block extracts up to sixteen properties from each frame and presents them together with a start strobe. The engine then walks an ordered table of rules at one rule per clock. Each rule selects one property with a 4-bit identifier and compares it with a stored value. Two control bits on each rule set what a hit or a miss does next. Depending on them, a hit can settle the outcome, hand the decision on to the following rule, or open a group of rules (a cluster). A miss can move on, skip the rest of a conjunction, or close a cluster.

Software fills the table through a write port while the engine is idle. A separate strobe sets the outcome used when no rule decides. Each evaluation ends with a one-cycle done pulse that carries the reject flag, the index of the deciding rule and a flag that marks a default decision. Clusters do not nest.

Top module: `ff_filter_engine`

## Requirements
- R1: After reset the engine is idle, `busy_o` and `done_o` are low, and `reject_o` and `by_default_o` are low.
- R2: A rule with cluster bit 0 and chain bit 0 ends evaluation on a hit, with reject taken from its reject bit. On a miss, evaluation moves to the next rule.
- R3: A rule with cluster bit 0 and chain bit 1 hands the decision to the next rule on a hit. On a miss, every later rule is skipped up to and including the next rule whose chain bit is 0.
- R4: When a failed chain is skipped through to a terminating rule whose cluster bit is 1, the engine also leaves the cluster it was in.
- R5: A rule with cluster bit 1 and chain bit 0 ends evaluation on a hit, with reject taken from its reject bit. On a miss, it closes the cluster and evaluation resumes at the following rule.
- R6: A rule with cluster bit 1 and chain bit 1 opens a cluster on a hit. On a miss, later rules are skipped up to and including the next rule with cluster bit 1 and chain bit 0.
- R7: A cluster-opening rule (cluster bit 1, chain bit 1) met while a cluster is already open rejects the frame, and that rule is reported as the deciding rule.
- R8: If evaluation passes the last rule without a decision, the stored default is applied, `by_default_o` is high and the reported index is DEPTH-1. The default is accept after reset. `dflt_we_i` sets it (1 = reject) while the engine is idle.
- R9: Property k occupies `props_i[k*VAL_W +: VAL_W]`. Identifier 4'b1010 selects an 8-bit type-of-service property and compares only bits 7:0 of the property and of the rule value. All other identifiers compare the full VAL_W bits.
- R10: One rule is evaluated per clock. When rule k decides, `done_o` rises k+1 clock edges after the edge that sampled start, and it stays high for exactly one cycle.
- R11: A start strobe that arrives while the engine is busy is ignored and does not change the running evaluation.
- R12: Rule writes issued while the engine is busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_we_i | input | 1 | Rule write strobe (honoured only when idle) |
| rule_addr_i | input | IDX_W | Rule index to write |
| rule_and_i | input | 1 | Chain bit of the written rule |
| rule_cle_i | input | 1 | Cluster bit of the written rule |
| rule_rej_i | input | 1 | Reject bit of the written rule |
| rule_pid_i | input | 4 | Property identifier of the written rule |
| rule_val_i | input | VAL_W | Comparison value of the written rule |
| dflt_we_i | input | 1 | Default outcome write strobe (honoured only when idle) |
| dflt_rej_i | input | 1 | Default outcome, 1 = reject |
| start_i | input | 1 | Start evaluation of one frame |
| props_i | input | 16*VAL_W | Extracted frame properties, sampled with start |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle decision pulse |
| reject_o | output | 1 | Decision: 1 = reject, 0 = accept |
| rule_idx_o | output | IDX_W | Index of the deciding rule |
| by_default_o | output | 1 | Decision came from the default outcome |

## Verification
The bench builds the engine with an 8-entry table and a 12-bit compare value. With the short table, the default path and a full walk of every rule finish in eight cycles, so the exact done cycle can be checked. The wide value lets a type-of-service rule differ from its property in bits 11:8 and still hit, which shows that only the low byte is compared. Chains, skips, cluster entry and exit and the nested-cluster error each use a short table, built so that a wrong skip lands on a rule with a different outcome or index.

// File: rtl/ff_filter_pkg.sv
package ff_filter_pkg;
  localparam int PID_W   = 4;
  localparam int NPROP   = 16;
  localparam int TOS_W   = 8;
  localparam logic [PID_W-1:0] PID_TOS = 4'b1010;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } walk_state_e;

  typedef enum logic [1:0] {
    WM_EVAL     = 2'd0,
    WM_SKIP_AND = 2'd1,
    WM_SKIP_CLU = 2'd2
  } walk_mode_e;
endpackage

// File: rtl/ff_rule_mem.sv
module ff_rule_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 23,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ff_prop_match.sv
module ff_prop_match
  import ff_filter_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic [NPROP*VAL_W-1:0] props,
  input  logic [PID_W-1:0]       pid,
  input  logic [VAL_W-1:0]       val,
  output logic                   hit
);
  logic [NPROP-1:0] hv;

  for (genvar g = 0; g < NPROP; g++) begin : g_cmp
    if (g == int'(PID_TOS)) begin : g_tos
      assign hv[g] = (props[g*VAL_W +: TOS_W] == val[TOS_W-1:0]);
    end else begin : g_full
      assign hv[g] = (props[g*VAL_W +: VAL_W] == val);
    end
  end

  assign hit = hv[pid];
endmodule

// File: rtl/ff_walk_ctl.sv
module ff_walk_ctl
  import ff_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dflt_rej_i,
  input  logic             r_and_i,
  input  logic             r_cle_i,
  input  logic             r_rej_i,
  input  logic             hit_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             done_o,
  output logic             reject_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             by_default_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  walk_state_e      st;
  walk_mode_e       mode, nxt_mode;
  logic [IDX_W-1:0] idx, idx_nxt;
  logic             in_clu, nxt_clu;
  logic             dec, dec_rej, dec_dflt;

  assign busy_o    = (st == ST_RUN);
  assign load_o    = (st == ST_IDLE) && start_i;
  assign idx_nxt   = idx + IDX_W'(1);
  assign rd_addr_o = (st == ST_RUN) ? idx_nxt : '0;

  always_comb begin
    dec      = 1'b0;
    dec_rej  = 1'b0;
    dec_dflt = 1'b0;
    nxt_mode = mode;
    nxt_clu  = in_clu;
    unique case (mode)
      WM_EVAL: begin
        unique case ({r_cle_i, r_and_i})
          2'b00: if (hit_i) begin dec = 1'b1; dec_rej = r_rej_i; end
          2'b01: if (!hit_i) nxt_mode = WM_SKIP_AND;
          2'b10: begin
            if (hit_i) begin dec = 1'b1; dec_rej = r_rej_i; end
            else nxt_clu = 1'b0;
          end
          default: begin
            if (in_clu) begin
              dec     = 1'b1;
              dec_rej = 1'b1;
            end else if (hit_i) begin
              nxt_clu = 1'b1;
            end else begin
              nxt_mode = WM_SKIP_CLU;
            end
          end
        endcase
      end
      WM_SKIP_AND: begin
        if (!r_and_i) begin
          nxt_mode = WM_EVAL;
          if (r_cle_i) nxt_clu = 1'b0;
        end
      end
      WM_SKIP_CLU: begin
        if (r_cle_i && !r_and_i) nxt_mode = WM_EVAL;
      end
      default: nxt_mode = WM_EVAL;
    endcase
    if (!dec && idx == LAST) begin
      dec      = 1'b1;
      dec_rej  = dflt_rej_i;
      dec_dflt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      mode         <= WM_EVAL;
      idx          <= '0;
      in_clu       <= 1'b0;
      done_o       <= 1'b0;
      reject_o     <= 1'b0;
      idx_o        <= '0;
      by_default_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st     <= ST_RUN;
            idx    <= '0;
            mode   <= WM_EVAL;
            in_clu <= 1'b0;
          end
        end
        default: begin
          if (dec) begin
            st           <= ST_IDLE;
            done_o       <= 1'b1;
            reject_o     <= dec_rej;
            idx_o        <= idx;
            by_default_o <= dec_dflt;
          end else begin
            idx    <= idx_nxt;
            mode   <= nxt_mode;
            in_clu <= nxt_clu;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_RULE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !dec) |=> (busy_o && idx == IDX_W'($past(idx) + 1'b1))); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R11
  AST_DEFAULT_LAST: assert property (@(posedge clk) disable iff (rst)
    (done_o && by_default_o) |-> (idx_o == LAST)); // R8
  AST_NESTED_REJECT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && mode == WM_EVAL && r_cle_i && r_and_i && in_clu)
      |=> (done_o && reject_o && !by_default_o)); // R7
endmodule

// File: rtl/ff_filter_engine.sv
module ff_filter_engine
  import ff_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VAL_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int RULE_W = VAL_W + PID_W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rule_we_i,
  input  logic [IDX_W-1:0]       rule_addr_i,
  input  logic                   rule_and_i,
  input  logic                   rule_cle_i,
  input  logic                   rule_rej_i,
  input  logic [PID_W-1:0]       rule_pid_i,
  input  logic [VAL_W-1:0]       rule_val_i,
  input  logic                   dflt_we_i,
  input  logic                   dflt_rej_i,
  input  logic                   start_i,
  input  logic [NPROP*VAL_W-1:0] props_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   reject_o,
  output logic [IDX_W-1:0]       rule_idx_o,
  output logic                   by_default_o
);
  logic [RULE_W-1:0]      wr_word, rd_word;
  logic [IDX_W-1:0]       rd_addr;
  logic                   mem_we, load, hit, dflt_q;
  logic [NPROP*VAL_W-1:0] props_q;

  assign wr_word = {rule_and_i, rule_cle_i, rule_rej_i, rule_pid_i, rule_val_i};
  assign mem_we  = rule_we_i && !busy_o;

  ff_rule_mem #(.DEPTH(DEPTH), .WIDTH(RULE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (rule_addr_i),
    .wdata (wr_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_q  <= 1'b0;
      props_q <= '0;
    end else begin
      if (dflt_we_i && !busy_o) dflt_q <= dflt_rej_i;
      if (load) props_q <= props_i;
    end
  end

  ff_prop_match #(.VAL_W(VAL_W)) u_match (
    .props (props_q),
    .pid   (rd_word[VAL_W +: PID_W]),
    .val   (rd_word[VAL_W-1:0]),
    .hit   (hit)
  );

  ff_walk_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .dflt_rej_i   (dflt_q),
    .r_and_i      (rd_word[RULE_W-1]),
    .r_cle_i      (rd_word[RULE_W-2]),
    .r_rej_i      (rd_word[RULE_W-3]),
    .hit_i        (hit),
    .busy_o       (busy_o),
    .load_o       (load),
    .rd_addr_o    (rd_addr),
    .done_o       (done_o),
    .reject_o     (reject_o),
    .idx_o        (rule_idx_o),
    .by_default_o (by_default_o)
  );

  AST_PROPS_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(props_q)); // R11
endmodule

// File: tb/ff_filter_engine_tb.sv
module ff_filter_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int VAL_W = 12;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PW = 16 * VAL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rule_we = 1'b0;
  logic [IDX_W-1:0] rule_addr = '0;
  logic             rule_and = 1'b0, rule_cle = 1'b0, rule_rej = 1'b0;
  logic [3:0]       rule_pid = '0;
  logic [VAL_W-1:0] rule_val = '0;
  logic             dflt_we = 1'b0, dflt_rej = 1'b0;
  logic             start = 1'b0;
  logic [PW-1:0]    props = '0;
  logic             busy, done, reject, by_def;
  logic [IDX_W-1:0] ridx;

  int checks = 0;
  int fails = 0;
  int r_rej, r_idx, r_dflt, r_cyc, r_extra;

  always #(CLK_PERIOD/2) clk = ~clk;

  ff_filter_engine #(.DEPTH(DEPTH), .VAL_W(VAL_W)) u_dut (
    .clk(clk), .rst(rst),
    .rule_we_i(rule_we), .rule_addr_i(rule_addr), .rule_and_i(rule_and),
    .rule_cle_i(rule_cle), .rule_rej_i(rule_rej), .rule_pid_i(rule_pid),
    .rule_val_i(rule_val), .dflt_we_i(dflt_we), .dflt_rej_i(dflt_rej),
    .start_i(start), .props_i(props),
    .busy_o(busy), .done_o(done), .reject_o(reject),
    .rule_idx_o(ridx), .by_default_o(by_def)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] std_props();
    logic [PW-1:0] p;
    for (int k = 0; k < 16; k++) p[k*VAL_W +: VAL_W] = VAL_W'(12'h100 | k);
    return p;
  endfunction

  function automatic logic [VAL_W-1:0] pv(input int k);
    return VAL_W'(12'h100 | k);
  endfunction

  task automatic wr(input int i, input logic a, input logic c, input logic rj,
                    input int pid, input logic [VAL_W-1:0] v);
    @(negedge clk);
    rule_we = 1'b1; rule_addr = IDX_W'(i); rule_and = a; rule_cle = c;
    rule_rej = rj; rule_pid = 4'(pid); rule_val = v;
    @(negedge clk);
    rule_we = 1'b0;
  endtask

  task automatic clear_table();
    for (int i = 0; i < DEPTH; i++) wr(i, 1'b0, 1'b0, 1'b1, 0, 12'hFFF);
  endtask

  task automatic set_default(input logic rj);
    @(negedge clk); dflt_we = 1'b1; dflt_rej = rj;
    @(negedge clk); dflt_we = 1'b0;
  endtask

  task automatic run(input logic [PW-1:0] p, input int restart_at, input int write_at);
    @(negedge clk);
    props = p; start = 1'b1;
    @(posedge clk);
    r_cyc = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && r_cyc < 100) begin
      start = (r_cyc == restart_at);
      if (r_cyc == restart_at) props = '0;
      if (r_cyc == write_at) begin
        rule_we = 1'b1; rule_addr = '0; rule_and = 1'b0; rule_cle = 1'b0;
        rule_rej = 1'b1; rule_pid = 4'd0; rule_val = pv(0);
      end else rule_we = 1'b0;
      @(posedge clk);
      r_cyc++;
      @(negedge clk);
    end
    start = 1'b0; rule_we = 1'b0;
    if (r_cyc >= 100) check("R10", "run timeout", r_cyc, 0);
    r_rej = int'(reject); r_idx = int'(ridx); r_dflt = int'(by_def);
    r_extra = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) r_extra++;
    end
  endtask

  task automatic expect_dec(input string req, input int rj, input int ix, input int df);
    check(req, "reject", r_rej, rj);
    check(req, "index", r_idx, ix);
    check(req, "by_default", r_dflt, df);
  endtask

  task automatic t_reset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "reject", int'(reject), 0);
    check("R1", "by_default", int'(by_def), 0);
  endtask

  task automatic t_plain();
    clear_table();
    wr(2, 1'b0, 1'b0, 1'b0, 3, pv(3));
    run(std_props(), -1, -1);
    expect_dec("R2", 0, 2, 0);
    check("R10", "latency rule2", r_cyc, 3);
    check("R10", "extra done", r_extra, 0);
    clear_table();
    wr(0, 1'b0, 1'b0, 1'b1, 5, pv(5));
    run(std_props(), -1, -1);
    expect_dec("R2", 1, 0, 0);
    check("R10", "latency rule0", r_cyc, 1);
  endtask

  task automatic t_chain();
    clear_table();
    wr(0, 1'b1, 1'b0, 1'b0, 1, pv(1));
    wr(1, 1'b0, 1'b0, 1'b1, 2, pv(2));
    run(std_props(), -1, -1);
    expect_dec("R3", 1, 1, 0);
    clear_table();
    wr(0, 1'b1, 1'b0, 1'b0, 1, 12'h0FF);
    wr(1, 1'b1, 1'b0, 1'b1, 2, pv(2));
    wr(2, 1'b0, 1'b0, 1'b1, 2, pv(2));
    wr(3, 1'b0, 1'b0, 1'b0, 4, pv(4));
    run(std_props(), -1, -1);
    expect_dec("R3", 0, 3, 0);
  endtask

  task automatic t_cluster();
    clear_table();
    wr(0, 1'b1, 1'b1, 1'b0, 1, pv(1));
    wr(2, 1'b0, 1'b1, 1'b1, 6, pv(6));
    run(std_props(), -1, -1);
    expect_dec("R6", 1, 2, 0);
    clear_table();
    wr(0, 1'b1, 1'b1, 1'b0, 1, 12'h0FF);
    wr(1, 1'b0, 1'b0, 1'b1, 2, pv(2));
    wr(2, 1'b0, 1'b1, 1'b1, 3, pv(3));
    wr(3, 1'b0, 1'b0, 1'b0, 4, pv(4));
    run(std_props(), -1, -1);
    expect_dec("R6", 0, 3, 0);
    clear_table();
    wr(0, 1'b1, 1'b1, 1'b0, 1, pv(1));
    wr(1, 1'b0, 1'b1, 1'b0, 2, 12'h0FF);
    wr(2, 1'b1, 1'b1, 1'b0, 3, pv(3));
    wr(3, 1'b0, 1'b1, 1'b1, 4, pv(4));
    run(std_props(), -1, -1);
    expect_dec("R5", 1, 3, 0);
    clear_table();
    wr(0, 1'b1, 1'b1, 1'b0, 1, pv(1));
    wr(1, 1'b1, 1'b0, 1'b0, 2, 12'h0FF);
    wr(2, 1'b0, 1'b1, 1'b1, 3, pv(3));
    wr(3, 1'b1, 1'b1, 1'b0, 4, pv(4));
    wr(4, 1'b0, 1'b1, 1'b0, 5, pv(5));
    run(std_props(), -1, -1);
    expect_dec("R4", 0, 4, 0);
    clear_table();
    wr(0, 1'b1, 1'b1, 1'b0, 1, pv(1));
    wr(1, 1'b1, 1'b1, 1'b0, 2, pv(2));
    wr(2, 1'b0, 1'b0, 1'b0, 3, pv(3));
    run(std_props(), -1, -1);
    expect_dec("R7", 1, 1, 0);
  endtask

  task automatic t_default();
    clear_table();
    run(std_props(), -1, -1);
    expect_dec("R8", 0, DEPTH-1, 1);
    check("R10", "latency full walk", r_cyc, DEPTH);
    set_default(1'b1);
    run(std_props(), -1, -1);
    expect_dec("R8", 1, DEPTH-1, 1);
    set_default(1'b0);
  endtask

  task automatic t_tos();
    clear_table();
    wr(0, 1'b0, 1'b0, 1'b1, 10, 12'hF0A);
    run(std_props(), -1, -1);
    expect_dec("R9", 1, 0, 0);
    clear_table();
    wr(0, 1'b0, 1'b0, 1'b1, 10, 12'h10B);
    wr(1, 1'b0, 1'b0, 1'b1, 9, 12'hF09);
    run(std_props(), -1, -1);
    expect_dec("R9", 0, DEPTH-1, 1);
  endtask

  task automatic t_busy();
    clear_table();
    wr(0, 1'b0, 1'b0, 1'b1, 0, 12'h000);
    run(std_props(), 3, -1);
    expect_dec("R11", 0, DEPTH-1, 1);
    check("R11", "latency with restart", r_cyc, DEPTH);
    check("R11", "extra done", r_extra, 0);
    clear_table();
    run(std_props(), -1, 2);
    expect_dec("R12", 0, DEPTH-1, 1);
    run(std_props(), -1, -1);
    expect_dec("R12", 0, DEPTH-1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_chain();
    t_cluster();
    t_default();
    t_tos();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule